// File: doc/BRIEF.md
# Panel Command Sequencer over a 3-Wire Serial Link

This block sends the initialisation and shutdown commands that a small LCD panel needs, over a transmit-only serial link made of a clock, a frame strobe and a data line. The command lists are held in on-chip constant storage as 32-bit packed words. The two top bits of each word say how many parameter bytes follow the opcode (none, one or two). The lower 30 bits hold 9-bit units, each led by a flag bit that is 0 for the opcode and 1 for a parameter. For each word the block picks a short or a long frame, shifts the units out most significant bit first, and waits until the word is fully sent before it starts the next one.

A host raises a one-cycle request and says whether it wants the power-up or the power-down sequence. It also gives the horizontal resolution of the panel mode in use. Power-up plays five lists in a fixed order, with a wide-mode or a narrow-mode variant of two of them chosen from the resolution. Power-down plays a single list. When the serial format has to change between words, the block leaves an extra idle interval before the next frame. A one-cycle done pulse marks the end of a sequence. Requests that arrive while a sequence is running are dropped.

Top module: `lcd_panel_seq`

## Requirements
- R1: A packed word carries its parameter count in bits 31:30 and its payload in bits 29:0. With zero or one parameter, the opcode unit is payload bits 17:9 and the single parameter unit is bits 8:0. With two parameters, the opcode unit is bits 26:18 and the two parameter units are bits 17:9 and 8:0. Each unit has bit 8 set to 0 for an opcode and 1 for a parameter.
- R2: A frame is 18 bits for zero or one parameter and 27 bits for two. The frame strobe is high for exactly that many rising serial clock edges. Data goes out most significant bit first, and a zero-parameter word sends its opcode unit followed by nine zero bits.
- R3: The serial clock is low whenever the frame strobe is low, and it starts low when a frame begins. Each clock phase lasts DIV_HALF system cycles. Data changes only while the clock falls, and it is stable while the clock is high.
- R4: Every frame ends before the next begins. If a word's parameter count differs from that of the previously sent word, or it is the first word since reset, the strobe stays low for at least RECONF_CYC system cycles before that frame. Between two words of one sequence that have the same count, the strobe-low gap is shorter than RECONF_CYC.
- R5: Power-up sends, in order: the panel-on list (0x29; 0xB8 with 0xFF, 0xF9; 0x11; 0xB0 with 0x16), the reset list, a pass-through list, the 27-word common configuration list, and a transfer list. The wide variants are used when the requested horizontal resolution is greater than 240 (241 is wide and 240 is narrow).
- R6: The reset list is opcode 0x01 followed by three 0x00 no-op words, all with no parameters.
- R7: Power-down sends 0x28, then 0xB8 with 0x80 and 0x02, then 0x10, then 0xB0 with 0x00.
- R8: The wide and narrow pass-through lists are 0xB0/0x16, 0xBC/x, 0xE1/0x00, 0x36/0x50, 0x3B/y, with (x,y) = (0x80,0x00) for wide and (0x81,0x22) for narrow.
- R9: `busy` rises in the cycle after an accepted request and stays high until the sequence ends. A request made while `busy` is high has no effect on the frames sent.
- R10: `done` is high for exactly one cycle per sequence, after the last frame has ended, and `busy` is low in that cycle.
- R11: After reset, the strobe, serial clock, data, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle sequence request |
| req_power_on | input | 1 | 1 selects power-up, 0 selects power-down |
| req_hres | input | HRES_W | Horizontal resolution used to pick wide or narrow lists |
| ser_clk | output | 1 | Serial clock |
| ser_frm | output | 1 | Frame strobe, high during a frame |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The checker assumes that reset is held for at least one clock before the first request and that `req_valid` is only sampled on clock edges. No other input needs to be constrained, because a request that arrives mid-sequence must be ignored. The bench drives requests one cycle wide, placed after a falling clock edge. It picks the sequence kind and the resolution at random, and it also places some requests while `busy` is high, so that the ignore rule is exercised rather than assumed. The wide/narrow limit is hit directly at resolutions 240 and 241.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int UNIT_W      = 9;
    localparam int FRAME_SHORT = 2 * UNIT_W;
    localparam int FRAME_LONG  = 3 * UNIT_W;
    localparam int IDX_W       = 5;
    localparam int CNT_W       = $clog2(FRAME_LONG + 1);

    typedef enum logic [2:0] {
        LST_ON, LST_RST, LST_PASS_W, LST_PASS_N,
        LST_CFG, LST_XFER_W, LST_XFER_N, LST_OFF
    } list_id_e;

    typedef struct packed {
        logic [1:0]  npar;
        logic [29:0] payload;
    } pword_t;

    typedef struct packed {
        logic [1:0]            npar;
        logic [FRAME_LONG-1:0] bits;
    } frame_t;

    function automatic pword_t w0(input logic [7:0] op);
        pword_t w = '0;
        w.payload[17:9] = {1'b0, op};
        return w;
    endfunction

    function automatic pword_t w1(input logic [7:0] op, input logic [7:0] p);
        pword_t w = '0;
        w.npar          = 2'd1;
        w.payload[17:9] = {1'b0, op};
        w.payload[8:0]  = {1'b1, p};
        return w;
    endfunction

    function automatic pword_t w2(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
        pword_t w = '0;
        w.npar           = 2'd2;
        w.payload[26:18] = {1'b0, op};
        w.payload[17:9]  = {1'b1, a};
        w.payload[8:0]   = {1'b1, b};
        return w;
    endfunction

    // R1: decode a packed word into a left-aligned frame
    function automatic frame_t decode(input pword_t w);
        frame_t f;
        f.npar = w.npar;
        if (w.npar[1]) f.bits = w.payload[FRAME_LONG-1:0];
        else           f.bits = {w.payload[FRAME_SHORT-1:0], {UNIT_W{1'b0}}};
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] list_len(input list_id_e id);
        case (id)
            LST_PASS_W, LST_PASS_N: return IDX_W'(5);
            LST_CFG:                return IDX_W'(27);
            LST_XFER_W, LST_XFER_N: return IDX_W'(9);
            default:                return IDX_W'(4);
        endcase
    endfunction

    function automatic pword_t short_word(input list_id_e id, input logic [IDX_W-1:0] i);
        case (id)
            LST_ON: case (i)
                0: return w0(8'h29);
                1: return w2(8'hB8, 8'hFF, 8'hF9);
                2: return w0(8'h11);
                default: return w1(8'hB0, 8'h16);
            endcase
            LST_RST: return (i == 0) ? w0(8'h01) : w0(8'h00);
            LST_OFF: case (i)
                0: return w0(8'h28);
                1: return w2(8'hB8, 8'h80, 8'h02);
                2: return w0(8'h10);
                default: return w1(8'hB0, 8'h00);
            endcase
            default: case (i)   // pass-through lists, R8
                0: return w1(8'hB0, 8'h16);
                1: return w1(8'hBC, (id == LST_PASS_W) ? 8'h80 : 8'h81);
                2: return w1(8'hE1, 8'h00);
                3: return w1(8'h36, 8'h50);
                default: return w1(8'h3B, (id == LST_PASS_W) ? 8'h00 : 8'h22);
            endcase
        endcase
    endfunction

    function automatic pword_t xfer_word(input logic wide, input logic [IDX_W-1:0] i);
        case (i)
            0: return wide ? w1(8'hCF, 8'h02)        : w1(8'hD6, 8'h02);
            1: return wide ? w2(8'hD0, 8'h08, 8'h04) : w2(8'hD7, 8'h08, 8'h04);
            2: return wide ? w1(8'hD1, 8'h01)        : w1(8'hD8, 8'h01);
            3: return wide ? w2(8'hD2, 8'h14, 8'h00) : w2(8'hD9, 8'h00, 8'h08);
            4: return wide ? w2(8'hD3, 8'h1A, 8'h0F) : w2(8'hDE, 8'h05, 8'h0A);
            5: return wide ? w2(8'hD4, 8'h1F, 8'hAF) : w2(8'hDF, 8'h0A, 8'h19);
            6: return wide ? w1(8'hD5, 8'h14)        : w1(8'hE0, 8'h0A);
            7: return w0(8'h21);
            default: return w0(8'h29);
        endcase
    endfunction

    function automatic pword_t cfg_word(input logic [IDX_W-1:0] i);
        case (i)
            0:  return w2(8'hB8, 8'hFF, 8'hF9);
            1:  return w0(8'h11);
            2:  return w1(8'hBA, 8'h01);
            3:  return w1(8'hBB, 8'h00);
            4:  return w1(8'h3A, 8'h60);
            5:  return w1(8'hBF, 8'h10);
            6:  return w1(8'hB1, 8'h56);
            7:  return w1(8'hB2, 8'h33);
            8:  return w1(8'hB3, 8'h11);
            9:  return w1(8'hB4, 8'h02);
            10: return w1(8'hB5, 8'h35);
            11: return w1(8'hB6, 8'h40);
            12: return w1(8'hB7, 8'h03);
            13: return w1(8'hBD, 8'h00);
            14: return w1(8'hBE, 8'h00);
            15: return w1(8'hC0, 8'h11);
            16: return w1(8'hC1, 8'h11);
            17: return w1(8'hC2, 8'h11);
            18: return w2(8'hC3, 8'h20, 8'h40);
            19: return w2(8'hC4, 8'h60, 8'hC0);
            20: return w2(8'hC5, 8'h10, 8'h20);
            21: return w1(8'hC6, 8'hC0);
            22: return w2(8'hC7, 8'h33, 8'h43);
            23: return w1(8'hC8, 8'h44);
            24: return w1(8'hC9, 8'h33);
            25: return w1(8'hCA, 8'h00);
            default: return w2(8'hEC, 8'h01, 8'hF0);
        endcase
    endfunction

    // R5: list played at each stage of a sequence
    function automatic list_id_e stage_list(input logic pwr_on, input logic wide, input logic [2:0] stage);
        if (!pwr_on) return LST_OFF;
        case (stage)
            3'd0: return LST_ON;
            3'd1: return LST_RST;
            3'd2: return wide ? LST_PASS_W : LST_PASS_N;
            3'd3: return LST_CFG;
            default: return wide ? LST_XFER_W : LST_XFER_N;
        endcase
    endfunction

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
    import lcd_seq_pkg::*;
(
    input  list_id_e         list_id,
    input  logic [IDX_W-1:0] word_idx,
    output frame_t           frame,
    output logic [IDX_W-1:0] len
);
    pword_t word;

    always_comb begin
        case (list_id)
            LST_CFG:    word = cfg_word(word_idx);
            LST_XFER_W: word = xfer_word(1'b1, word_idx);
            LST_XFER_N: word = xfer_word(1'b0, word_idx);
            default:    word = short_word(list_id, word_idx);
        endcase
    end

    assign frame = decode(word);
    assign len   = list_len(list_id);

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
    import lcd_seq_pkg::*;
#(
    parameter int HRES_W     = 12,
    parameter int WIDE_LIMIT = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_power_on,
    input  logic [HRES_W-1:0] req_hres,
    input  logic              word_done,
    input  logic [IDX_W-1:0]  len,
    output list_id_e          list_id,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_valid,
    output logic              busy,
    output logic              done
);
    typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} ctrl_st_e;

    ctrl_st_e   st;
    logic       on_q;
    logic       wide_q;
    logic [2:0] stage;
    logic [2:0] last_stage;

    assign list_id    = stage_list(on_q, wide_q, stage);
    assign last_stage = on_q ? 3'd4 : 3'd0;
    assign word_valid = (st == C_ISSUE);
    assign busy       = (st != C_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            on_q     <= 1'b0;
            wide_q   <= 1'b0;
            stage    <= '0;
            word_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                C_IDLE: if (req_valid) begin
                    on_q     <= req_power_on;
                    wide_q   <= (req_hres > HRES_W'(WIDE_LIMIT));
                    stage    <= '0;
                    word_idx <= '0;
                    st       <= C_ISSUE;
                end
                C_ISSUE: st <= C_WAIT;
                default: if (word_done) begin
                    if (word_idx == len - 1'b1) begin
                        word_idx <= '0;
                        if (stage == last_stage) begin
                            done <= 1'b1;
                            st   <= C_IDLE;
                        end else begin
                            stage <= stage + 1'b1;
                            st    <= C_ISSUE;
                        end
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        st       <= C_ISSUE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lcd_seq_shifter.sv
module lcd_seq_shifter
    import lcd_seq_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int GAP_CYC    = 4,
    parameter int RECONF_CYC = 24
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   word_valid,
    input  frame_t frame,
    output logic   word_done,
    output logic   ser_clk,
    output logic   ser_frm,
    output logic   ser_dat
);
    localparam int TMAX = (RECONF_CYC > GAP_CYC) ? RECONF_CYC : GAP_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int HW   = $clog2(DIV_HALF + 1);

    typedef enum logic [1:0] {X_IDLE, X_RECONF, X_SHIFT, X_GAP} shift_st_e;

    shift_st_e             st;
    logic [FRAME_LONG-1:0] sh;
    logic [CNT_W-1:0]      rem;
    logic [HW-1:0]         hc;
    logic [TW-1:0]         tmr;
    logic [1:0]            last_npar;
    logic                  last_vld;

    assign ser_dat = ser_frm & sh[FRAME_LONG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= X_IDLE;
            sh        <= '0;
            rem       <= '0;
            hc        <= '0;
            tmr       <= '0;
            last_npar <= '0;
            last_vld  <= 1'b0;
            word_done <= 1'b0;
            ser_clk   <= 1'b0;
            ser_frm   <= 1'b0;
        end else begin
            word_done <= 1'b0;
            case (st)
                X_IDLE: if (word_valid) begin
                    sh        <= frame.bits;
                    rem       <= frame.npar[1] ? CNT_W'(FRAME_LONG) : CNT_W'(FRAME_SHORT);
                    last_npar <= frame.npar;
                    last_vld  <= 1'b1;
                    hc        <= '0;
                    ser_clk   <= 1'b0;
                    if (!last_vld || frame.npar != last_npar) begin
                        st  <= X_RECONF;
                        tmr <= TW'(RECONF_CYC - 1);
                    end else begin
                        st      <= X_SHIFT;
                        ser_frm <= 1'b1;
                    end
                end
                X_RECONF: begin
                    if (tmr == '0) begin
                        st      <= X_SHIFT;
                        ser_frm <= 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                X_SHIFT: begin
                    if (hc == HW'(DIV_HALF - 1)) begin
                        hc      <= '0;
                        ser_clk <= ~ser_clk;
                        if (ser_clk) begin
                            if (rem == CNT_W'(1)) begin
                                ser_frm <= 1'b0;
                                st      <= X_GAP;
                                tmr     <= TW'(GAP_CYC - 1);
                            end else begin
                                rem <= rem - 1'b1;
                                sh  <= {sh[FRAME_LONG-2:0], 1'b0};
                            end
                        end
                    end else begin
                        hc <= hc + 1'b1;
                    end
                end
                default: begin
                    if (tmr == '0) begin
                        word_done <= 1'b1;
                        st        <= X_IDLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lcd_panel_seq.sv
module lcd_panel_seq
    import lcd_seq_pkg::*;
#(
    parameter int HRES_W     = 12,
    parameter int WIDE_LIMIT = 240,
    parameter int DIV_HALF   = 2,
    parameter int GAP_CYC    = 4,
    parameter int RECONF_CYC = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_power_on,
    input  logic [HRES_W-1:0] req_hres,
    output logic              ser_clk,
    output logic              ser_frm,
    output logic              ser_dat,
    output logic              busy,
    output logic              done
);
    list_id_e         list_id;
    logic [IDX_W-1:0] word_idx;
    logic [IDX_W-1:0] len;
    frame_t           frame;
    logic             word_valid;
    logic             word_done;

    lcd_seq_ctrl #(
        .HRES_W     (HRES_W),
        .WIDE_LIMIT (WIDE_LIMIT)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_power_on (req_power_on),
        .req_hres     (req_hres),
        .word_done    (word_done),
        .len          (len),
        .list_id      (list_id),
        .word_idx     (word_idx),
        .word_valid   (word_valid),
        .busy         (busy),
        .done         (done)
    );

    lcd_seq_rom rom_i (
        .list_id  (list_id),
        .word_idx (word_idx),
        .frame    (frame),
        .len      (len)
    );

    lcd_seq_shifter #(
        .DIV_HALF   (DIV_HALF),
        .GAP_CYC    (GAP_CYC),
        .RECONF_CYC (RECONF_CYC)
    ) shift_i (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .frame      (frame),
        .word_done  (word_done),
        .ser_clk    (ser_clk),
        .ser_frm    (ser_frm),
        .ser_dat    (ser_dat)
    );

endmodule

// File: rtl/lcd_panel_seq_chk.sv
module lcd_panel_seq_chk (
    input logic clk,
    input logic rst,
    input logic ser_clk,
    input logic ser_frm,
    input logic ser_dat,
    input logic busy,
    input logic done
);
    logic [4:0] rise_cnt;
    logic       clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt <= '0;
            clk_q    <= 1'b0;
        end else begin
            clk_q <= ser_clk;
            if (!ser_frm)              rise_cnt <= '0;
            else if (ser_clk && !clk_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R2: a frame holds exactly 18 or 27 rising serial clock edges
    p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_frm) |-> (rise_cnt == 5'd18 || rise_cnt == 5'd27));

    // R3: clock idles low outside a frame
    p_clk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !ser_frm |-> !ser_clk);

    // R3: a frame starts with the clock low
    p_frame_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_frm) |-> !ser_clk);

    // R3: data holds while the clock is high
    p_dat_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (ser_frm && $past(ser_frm) && ser_clk) |-> $stable(ser_dat));

    // R9: no frame activity without a running sequence
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_frm);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done only after the sequence has left the busy state
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !ser_frm));

endmodule

bind lcd_panel_seq lcd_panel_seq_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .ser_clk (ser_clk),
    .ser_frm (ser_frm),
    .ser_dat (ser_dat),
    .busy    (busy),
    .done    (done)
);

// File: tb/lcd_panel_seq_tb.sv
module lcd_panel_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HRES_W     = 12;
    localparam int DIV_HALF   = 2;
    localparam int GAP_CYC    = 4;
    localparam int RECONF_CYC = 24;
    localparam int MAXF       = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_power_on = 1'b0;
    logic [HRES_W-1:0] req_hres = '0;
    logic              ser_clk, ser_frm, ser_dat, busy, done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_panel_seq #(
        .HRES_W     (HRES_W),
        .WIDE_LIMIT (240),
        .DIV_HALF   (DIV_HALF),
        .GAP_CYC    (GAP_CYC),
        .RECONF_CYC (RECONF_CYC)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_power_on (req_power_on),
        .req_hres     (req_hres),
        .ser_clk      (ser_clk),
        .ser_frm      (ser_frm),
        .ser_dat      (ser_dat),
        .busy         (busy),
        .done         (done)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // capture of serial frames
    int          nfr = 0;
    int          cap_len [MAXF];
    logic [26:0] cap_val [MAXF];
    int          cap_gap [MAXF];
    int          cur_bits = 0;
    logic [26:0] cur_val = '0;
    int          gap_cnt = 0;
    int          hi_cnt = 0;
    int          hi_bad = 0;
    int          done_cnt = 0;
    int          frames_at_done = -1;
    logic        prev_clk = 1'b0;
    logic        prev_frm = 1'b0;

    // expected frames
    int    ne = 0;
    int    ex_cnt [MAXF];
    int    ex_op  [MAXF];
    int    ex_p1  [MAXF];
    int    ex_p2  [MAXF];
    string ex_req [MAXF];
    int    last_cnt = -1;

    always @(negedge clk) begin
        cycles++;
        if (ser_frm && !prev_frm) begin
            cur_bits = 0;
            cur_val  = '0;
            if (nfr < MAXF) cap_gap[nfr] = gap_cnt;
        end
        if (ser_frm && ser_clk && !prev_clk) begin
            cur_val = {cur_val[25:0], ser_dat};
            cur_bits++;
        end
        if (ser_clk) hi_cnt++;
        else if (prev_clk) begin
            if (hi_cnt != DIV_HALF) hi_bad++;
            hi_cnt = 0;
        end
        if (!ser_frm && prev_frm) begin
            if (nfr < MAXF) begin
                cap_len[nfr] = cur_bits;
                cap_val[nfr] = cur_val;
            end
            nfr++;
            gap_cnt = 0;
        end
        if (!ser_frm) gap_cnt++;
        if (done) begin
            done_cnt++;
            frames_at_done = nfr;
        end
        prev_clk = ser_clk;
        prev_frm = ser_frm;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int c, input int op, input int a, input int b, input string r);
        ex_cnt[ne] = c; ex_op[ne] = op; ex_p1[ne] = a; ex_p2[ne] = b; ex_req[ne] = r;
        ne++;
    endtask

    task automatic add_pass(input bit wide);
        push(1, 'hB0, 'h16, 0, "R8");
        push(1, 'hBC, wide ? 'h80 : 'h81, 0, "R8");
        push(1, 'hE1, 'h00, 0, "R8");
        push(1, 'h36, 'h50, 0, "R8");
        push(1, 'h3B, wide ? 'h00 : 'h22, 0, "R8");
    endtask

    task automatic add_cfg();
        push(2, 'hB8, 'hFF, 'hF9, "R5"); push(0, 'h11, 0, 0, "R5");
        push(1, 'hBA, 'h01, 0, "R5");    push(1, 'hBB, 'h00, 0, "R5");
        push(1, 'h3A, 'h60, 0, "R5");    push(1, 'hBF, 'h10, 0, "R5");
        push(1, 'hB1, 'h56, 0, "R5");    push(1, 'hB2, 'h33, 0, "R5");
        push(1, 'hB3, 'h11, 0, "R5");    push(1, 'hB4, 'h02, 0, "R5");
        push(1, 'hB5, 'h35, 0, "R5");    push(1, 'hB6, 'h40, 0, "R5");
        push(1, 'hB7, 'h03, 0, "R5");    push(1, 'hBD, 'h00, 0, "R5");
        push(1, 'hBE, 'h00, 0, "R5");    push(1, 'hC0, 'h11, 0, "R5");
        push(1, 'hC1, 'h11, 0, "R5");    push(1, 'hC2, 'h11, 0, "R5");
        push(2, 'hC3, 'h20, 'h40, "R5"); push(2, 'hC4, 'h60, 'hC0, "R5");
        push(2, 'hC5, 'h10, 'h20, "R5"); push(1, 'hC6, 'hC0, 0, "R5");
        push(2, 'hC7, 'h33, 'h43, "R5"); push(1, 'hC8, 'h44, 0, "R5");
        push(1, 'hC9, 'h33, 0, "R5");    push(1, 'hCA, 'h00, 0, "R5");
        push(2, 'hEC, 'h01, 'hF0, "R5");
    endtask

    task automatic add_xfer(input bit wide);
        if (wide) begin
            push(1, 'hCF, 'h02, 0, "R5");    push(2, 'hD0, 'h08, 'h04, "R5");
            push(1, 'hD1, 'h01, 0, "R5");    push(2, 'hD2, 'h14, 'h00, "R5");
            push(2, 'hD3, 'h1A, 'h0F, "R5"); push(2, 'hD4, 'h1F, 'hAF, "R5");
            push(1, 'hD5, 'h14, 0, "R5");
        end else begin
            push(1, 'hD6, 'h02, 0, "R5");    push(2, 'hD7, 'h08, 'h04, "R5");
            push(1, 'hD8, 'h01, 0, "R5");    push(2, 'hD9, 'h00, 'h08, "R5");
            push(2, 'hDE, 'h05, 'h0A, "R5"); push(2, 'hDF, 'h0A, 'h19, "R5");
            push(1, 'hE0, 'h0A, 0, "R5");
        end
        push(0, 'h21, 0, 0, "R5");
        push(0, 'h29, 0, 0, "R5");
    endtask

    task automatic build(input bit pwr_on, input bit wide);
        ne = 0;
        if (!pwr_on) begin
            push(0, 'h28, 0, 0, "R7");       push(2, 'hB8, 'h80, 'h02, "R7");
            push(0, 'h10, 0, 0, "R7");       push(1, 'hB0, 'h00, 0, "R7");
        end else begin
            push(0, 'h29, 0, 0, "R5");       push(2, 'hB8, 'hFF, 'hF9, "R5");
            push(0, 'h11, 0, 0, "R5");       push(1, 'hB0, 'h16, 0, "R5");
            push(0, 'h01, 0, 0, "R6");
            for (int k = 0; k < 3; k++) push(0, 'h00, 0, 0, "R6");
            add_pass(wide);
            add_cfg();
            add_xfer(wide);
        end
    endtask

    // R1/R2: expected serial bits, built unit by unit
    function automatic logic [26:0] exp_bits(input int k);
        logic [8:0] u0, u1, u2;
        u0 = {1'b0, 8'(ex_op[k])};
        u1 = {1'b1, 8'(ex_p1[k])};
        u2 = {1'b1, 8'(ex_p2[k])};
        case (ex_cnt[k])
            0:       return {9'b0, u0, 9'b0};
            1:       return {9'b0, u0, u1};
            default: return {u0, u1, u2};
        endcase
    endfunction

    task automatic run_seq(input bit pwr_on, input int hres, input bit inject);
        bit wide;
        int t;
        wide = (hres > 240);
        build(pwr_on, wide);
        @(negedge clk); #1;
        nfr = 0; done_cnt = 0; frames_at_done = -1; hi_bad = 0;
        req_valid = 1'b1; req_power_on = pwr_on; req_hres = HRES_W'(hres);
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after request", busy, 1);
        if (inject) begin
            repeat (300) @(negedge clk);
            #1;
            req_valid = 1'b1; req_power_on = !pwr_on; req_hres = HRES_W'(hres > 240 ? 100 : 480);
            @(negedge clk); #1;
            req_valid = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (5) @(negedge clk);
        #1;
        chk(done_cnt == 1, "R10", "done high cycles", done_cnt, 1);
        chk(frames_at_done == ne, "R10", "frames before done", frames_at_done, ne);
        chk(busy == 1'b0, "R9", "busy after done", busy, 0);
        chk(nfr == ne, inject ? "R9" : "R5", "frame count", nfr, ne);
        chk(hi_bad == 0, "R3", "clock high phase errors", hi_bad, 0);
        for (int k = 0; k < ne && k < nfr; k++) begin
            int elen;
            elen = (ex_cnt[k] == 2) ? 27 : 18;
            chk(cap_len[k] == elen, "R2", $sformatf("frame %0d length", k), cap_len[k], elen);
            chk(cap_val[k] == exp_bits(k), ex_req[k], $sformatf("frame %0d bits", k),
                cap_val[k], exp_bits(k));
            if (ex_cnt[k] != last_cnt)
                chk(cap_gap[k] >= RECONF_CYC, "R4", $sformatf("frame %0d reconfig gap", k),
                    cap_gap[k], RECONF_CYC);
            else if (k > 0)
                chk(cap_gap[k] < RECONF_CYC, "R4", $sformatf("frame %0d plain gap", k),
                    cap_gap[k], RECONF_CYC);
            last_cnt = ex_cnt[k];
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(ser_frm == 0 && ser_clk == 0 && ser_dat == 0, "R11", "serial idle in reset",
            {ser_frm, ser_clk, ser_dat}, 0);
        chk(busy == 0 && done == 0, "R11", "status in reset", {busy, done}, 0);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(ser_frm == 0 && busy == 0, "R11", "idle after reset", {ser_frm, busy}, 0);
        run_seq(1'b0, 0, 1'b0);      // R7, first word forces reconfig (R4)
        run_seq(1'b1, 240, 1'b0);    // R5 narrow boundary, R6, R8
        run_seq(1'b1, 241, 1'b0);    // R5 wide boundary
        run_seq(1'b1, 480, 1'b1);    // R9 request while busy
        run_seq(1'b0, 0, 1'b1);      // R9 request while busy, power-down
        for (int n = 0; n < 4; n++) begin
            bit pon;
            int hr;
            pon = ($urandom % 3) != 0;
            hr  = 1 + ($urandom % 640);
            run_seq(pon, hr, ($urandom % 4) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule